// File: doc/BRIEF.md
# Serial Side-Band Clock Output Enable Controller

This block controls which outputs of a clock fan-out bank are running. A three-wire serial port (data, shift clock and an active-low shift/commit strobe) loads one enable bit per output into a shift register. A falling edge on the strobe then copies all the bits into an output register at once. Each output also has an enable bit from a register that a host bus writes. That register lives outside this block and arrives here as a plain input vector. An output runs only when both of its bits are set.

For each output, the merged enable is retimed into that output's own reference clock. The reference clock is gated so that an output starts or stops only between pulses, whichever source made the change. The MSB of the shift register drives a serial-out pin. Devices can therefore share the shift clock and data with one strobe each (star wiring), or pass bits from one device to the next (chained wiring).

Top module: `sideband_oe_ctrl`

## Requirements
- R1: While reset is high, every gated output is held low. Reset sets the shift register and the output register to all ones, so the serial-out pin reads 1 and every output runs once reset is released.
- R2: On each rising edge of the shift clock while the strobe is high, the data input enters bit 0 of the shift register and every other bit moves one place toward the MSB.
- R3: Shift clock edges that arrive while the strobe is low leave the shift register unchanged.
- R4: A falling edge of the strobe copies all N shift register bits into the output register. Bit i controls output i, 1 meaning enabled. Between falling edges the output register holds its value.
- R5: A gated output never emits a shortened high pulse. Every high pulse lasts exactly the high phase of its reference clock.
- R6: Output i runs only when output register bit i and host enable bit i are both 1.
- R7: A change of the merged enable for output i takes effect on the second falling edge of reference clock i, through a two-flop retiming chain.
- R8: The serial-out pin shows the shift register MSB. With two devices chained, 2N shifts followed by one shared strobe fall load the first N bits shifted into the far device and the last N bits into the near device.
- R9: With shared shift clock and data and a separate strobe per device, only the device whose strobe is pulsed changes its outputs.
- R10: The number of outputs N is a parameter (default 20), and the shift register is exactly N bits long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high reset |
| sclk | input | 1 | Serial shift clock |
| ld_n | input | 1 | Active-low strobe: shift while high, commit on its falling edge |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output (shift register MSB) |
| host_oe | input | N | Host-written enable bits, one per output |
| ref_clk | input | N | Reference clocks to be gated |
| clk_out | output | N | Gated clock outputs |

## Verification
The bench keeps the shift clock running while the strobe is low and toggles the data input, then pulses the strobe without any shift edge. A design that shifted during the strobe-low phase would commit garbage instead of the earlier pattern. In star wiring, the bench loads one device while the other's strobe stays low. A design that committed on a shared event would disturb the idle device. Each gated output's high pulses are timed against its own reference half-period, across reference clocks of four different periods, so any gate that changes while the clock is high shows up as a short pulse. The chained load checks bit order across the device boundary: an MSB/LSB swap, or a serial-out taken from the wrong end, puts the wrong word into each device.

// File: rtl/sboe_pkg.sv
package sboe_pkg;
  localparam int unsigned SBOE_OUTS_DEF = 20;

  typedef enum logic {
    GATE_OFF = 1'b0,
    GATE_ON  = 1'b1
  } gate_state_e;
endpackage

// File: rtl/sboe_shift.sv
module sboe_shift #(
  parameter int unsigned N = sboe_pkg::SBOE_OUTS_DEF
) (
  input  logic         rst,
  input  logic         sclk,
  input  logic         ld_n,
  input  logic         sdi,
  output logic         sdo,
  output logic [N-1:0] oreg
);
  localparam int unsigned MSB = N - 1;

  logic [N-1:0] sr;

  // Shift while the strobe is high; reset is synchronous to the shift clock.
  always_ff @(posedge sclk) begin
    if (rst)
      sr <= '1;
    else if (ld_n)
      sr <= {sr[MSB-1:0], sdi};
  end

  // The strobe's falling edge is the only event that commits; it may come
  // with no shift clock running, so it clocks the output register itself.
  always_ff @(negedge ld_n or posedge rst) begin
    if (rst)
      oreg <= '1;
    else
      oreg <= sr;
  end

  assign sdo = sr[MSB];

  // R2: one bit enters at position 0, the rest move up
  p_shift_in_r2: assert property (@(posedge sclk) disable iff (rst)
    ld_n |=> (sr[0] == $past(sdi)) && (sr[MSB:1] == $past(sr[MSB-1:0])));

  // R3: no shifting while the strobe is low
  p_idle_hold_r3: assert property (@(posedge sclk) disable iff (rst)
    !ld_n |=> $stable(sr));
endmodule

// File: rtl/sboe_gate.sv
module sboe_gate (
  input  logic rst,
  input  logic clk_i,
  input  logic en_in,
  output logic clk_o
);
  import sboe_pkg::*;

  gate_state_e en_s1, en_s2;

  // Retime on the falling edge so the gate only moves while clk_i is low.
  always_ff @(negedge clk_i) begin
    if (rst) begin
      en_s1 <= GATE_OFF;
      en_s2 <= GATE_OFF;
    end else begin
      en_s1 <= gate_state_e'(en_in);
      en_s2 <= en_s1;
    end
  end

  assign clk_o = clk_i & (en_s2 == GATE_ON);

  // R5: the gate control never moves during the high phase
  always @(en_s2) begin
    if (!rst)
      p_gate_low_r5: assert (!clk_i);
  end

  // R7: a rise of the gate follows an enable seen two falling edges earlier
  p_two_stage_r7: assert property (@(negedge clk_i) disable iff (rst)
    (en_s2 == GATE_ON) && ($past(en_s2) == GATE_OFF) |-> $past(en_in, 2));
endmodule

// File: rtl/sideband_oe_ctrl.sv
module sideband_oe_ctrl #(
  parameter int unsigned N = sboe_pkg::SBOE_OUTS_DEF
) (
  input  logic         rst,
  input  logic         sclk,
  input  logic         ld_n,
  input  logic         sdi,
  output logic         sdo,
  input  logic [N-1:0] host_oe,
  input  logic [N-1:0] ref_clk,
  output logic [N-1:0] clk_out
);
  logic [N-1:0] oreg;
  logic [N-1:0] en_merged;

  sboe_shift #(.N(N)) u_shift (
    .rst  (rst),
    .sclk (sclk),
    .ld_n (ld_n),
    .sdi  (sdi),
    .sdo  (sdo),
    .oreg (oreg)
  );

  assign en_merged = oreg & host_oe;

  for (genvar i = 0; i < int'(N); i++) begin : g_out
    sboe_gate u_gate (
      .rst   (rst),
      .clk_i (ref_clk[i]),
      .en_in (en_merged[i]),
      .clk_o (clk_out[i])
    );
  end
endmodule

// File: tb/sim_sideband_oe_ctrl.sv
`timescale 1ns/1ps
module sim_sideband_oe_ctrl;
  localparam int N = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz, drives the shared shift clock

  logic rst = 1'b0;
  logic ld0 = 1'b0, ld1 = 1'b0, sdi = 1'b0, chain = 1'b0;
  logic [N-1:0] host0 = '1, host1 = '1;
  wire  [N-1:0] ref_clk, g0, g1;
  wire  sdo0, sdo1;
  wire  sdi1 = chain ? sdo0 : sdi;

  sideband_oe_ctrl #(.N(N)) u0 (.rst(rst), .sclk(clk), .ld_n(ld0), .sdi(sdi),
    .sdo(sdo0), .host_oe(host0), .ref_clk(ref_clk), .clk_out(g0));
  sideband_oe_ctrl #(.N(N)) u1 (.rst(rst), .sclk(clk), .ld_n(ld1), .sdi(sdi1),
    .sdo(sdo1), .host_oe(host1), .ref_clk(ref_clk), .clk_out(g1));

  int checks = 0, errors = 0;
  bit done = 0;
  int pc0[N], pc1[N], rc0[N], rc1[N];

  for (genvar i = 0; i < N; i++) begin : g_ref
    localparam int HP = 5 + (i % 4);
    logic rc = 1'b0;
    initial forever #(HP) rc = ~rc;
    assign ref_clk[i] = rc;

    realtime tr0, tr1;
    bit up0 = 0, up1 = 0;
    initial begin pc0[i] = 0; rc0[i] = 0; pc1[i] = 0; rc1[i] = 0; end
    always @(g0[i]) begin
      if (g0[i] === 1'b1 && !rst) begin tr0 = $realtime; up0 = 1; pc0[i]++; end
      else if (g0[i] === 1'b0 && up0) begin
        up0 = 0;
        if ($realtime - tr0 < HP - 0.01 || $realtime - tr0 > HP + 0.01) rc0[i]++;
      end
    end
    always @(g1[i]) begin
      if (g1[i] === 1'b1 && !rst) begin tr1 = $realtime; up1 = 1; pc1[i]++; end
      else if (g1[i] === 1'b0 && up1) begin
        up1 = 0;
        if ($realtime - tr1 < HP - 0.01 || $realtime - tr1 > HP + 0.01) rc1[i]++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int           dev;
    logic [N-1:0] exp;
    string        req;
  } item_t;
  item_t q[$];
  bit busy = 0;

  // Monitor: pops an expected enable set, lets it settle, counts pulses.
  initial forever begin
    item_t it;
    int snap[N];
    logic [N-1:0] seen;
    wait (q.size() > 0);
    busy = 1;
    it = q.pop_front();
    #40;
    for (int i = 0; i < N; i++) snap[i] = (it.dev == 0) ? pc0[i] : pc1[i];
    #100;
    for (int i = 0; i < N; i++)
      seen[i] = (((it.dev == 0) ? pc0[i] : pc1[i]) - snap[i]) > 0;
    check(seen == it.exp, it.req, $sformatf("running outputs dev%0d", it.dev),
          seen, it.exp);
    busy = 0;
  end

  task automatic expect_en(input int dev, input logic [N-1:0] e, input string req);
    item_t it;
    it.dev = dev; it.exp = e; it.req = req;
    q.push_back(it);
    wait (q.size() == 0 && !busy);
  endtask

  task automatic send_word(input logic [N-1:0] v);
    for (int b = N - 1; b >= 0; b--) begin
      sdi = v[b];
      @(negedge clk);
    end
  endtask

  task automatic load_star(input int dev, input logic [N-1:0] v);
    @(negedge clk);
    if (dev == 0) ld0 = 1'b1; else ld1 = 1'b1;
    send_word(v);
    ld0 = 1'b0; ld1 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [N-1:0] PA = 20'hA5C3E, PB = 20'h0F0F1;
  localparam logic [N-1:0] W0 = 20'h1234B, W1 = 20'hC0FFE;

  initial begin
    int s0, s1;
    #1 rst = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    check(g0 == '0 && g1 == '0, "R1", "outputs low in reset", g0 | g1, '0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    check(sdo0 == 1'b1 && sdo1 == 1'b1, "R1", "serial out after reset",
          {sdo1, sdo0}, 2'b11);
    expect_en(0, '1, "R1");
    expect_en(1, '1, "R1");

    // Star wiring: only the strobed device changes
    load_star(0, PA);
    expect_en(0, PA, "R2 R4");
    expect_en(1, '1, "R9");
    @(negedge clk); #1;
    check(sdo0 == PA[N-1], "R8", "serial out is MSB", sdo0, PA[N-1]);

    load_star(1, PB);
    expect_en(1, PB, "R9");
    expect_en(0, PA, "R9");

    // Shift clock keeps running with strobe low and data toggling
    for (int k = 0; k < 25; k++) begin @(negedge clk); sdi = k[0] ^ k[2]; end
    @(negedge clk); #1 ld0 = 1'b1; #2 ld0 = 1'b0;  // commit, no shift edge
    expect_en(0, PA, "R3");

    load_star(0, '0);
    expect_en(0, '0, "R4");
    load_star(0, '1);
    expect_en(0, '1, "R4");

    // Host-side enables
    host0 = 20'h3FF00;
    expect_en(0, 20'h3FF00, "R6 R7");
    load_star(0, 20'h5555A);
    expect_en(0, 20'h5555A & 20'h3FF00, "R6");
    host0 = '1;
    expect_en(0, 20'h5555A, "R6 R7");

    // Two-device chain: far word shifted first
    chain = 1'b1;
    @(negedge clk); ld0 = 1'b1; ld1 = 1'b1;
    send_word(W1);
    send_word(W0);
    ld0 = 1'b0; ld1 = 1'b0;
    @(negedge clk); #1;
    check(sdo0 == W0[N-1] && sdo1 == W1[N-1], "R8", "chain serial outs",
          {sdo1, sdo0}, {W1[N-1], W0[N-1]});
    expect_en(0, W0, "R8 R10");
    expect_en(1, W1, "R8 R10");
    chain = 1'b0;

    s0 = 0; s1 = 0;
    for (int i = 0; i < N; i++) begin s0 += rc0[i]; s1 += rc1[i]; end
    check(s0 == 0, "R5", "short pulses dev0", N'(s0), '0);
    check(s1 == 0, "R5", "short pulses dev1", N'(s1), '0);
    finish_run();
  end
endmodule